// File: doc/BRIEF.md
# Vertical Sync-Loss Detector with Free-Running Field Reference

This block watches the vertical sync pulses that a composite sync separator delivers and decides when the video input has gone away. An auxiliary line counter advances on an internal line-rate strobe. Its period is 269 lines when the 525-line standard is selected and 321 lines when the 625-line standard is selected. If a whole period passes without a vertical sync, the block reports a no-signal condition.

While the signal is absent, the same counter takes over as the field reference. It emits a one-line vertical reference pulse at every wrap, so the downstream vertical drive, vertical start and frame-reversal polarity keep toggling and the panel stays AC driven. In the same state the block tells the horizontal PLL counter to run free instead of being reset by horizontal sync. It also drops the drive enable of the phase-detector output so that the pin floats and feeds no false error to the loop filter.

A detected vertical sync returns the block to normal operation at once. In normal operation the vertical reference follows the incoming sync.

Top module: `sync_loss_detect`

## Requirements
- R1: After a vertical sync or a counter wrap, the counter wraps on the Nth following `line_tick`, where N is 269 when the latched standard is 0 (525-line) and 321 when it is 1 (625-line). Each wrap sets `no_signal` on the next clock.
- R2: A `vsync_det` pulse clears `no_signal` on the next clock and restarts the counter from zero. It takes priority over a `line_tick` in the same cycle.
- R3: `std_pal` is sampled only at a counter wrap and during reset. A change between wraps does not alter the length of the period in progress.
- R4: At a wrap, `vref` goes high on the next clock and stays high until the clock after the next `line_tick`, a pulse one line long. A `vsync_det` ends it early.
- R5: With a signal present, `vref` is a one-clock pulse in the cycle after each `vsync_det`.
- R6: `frame_pol` toggles on every clock where a `vref` pulse starts, whether that pulse comes from a vertical sync or from a wrap.
- R7: `pd_drive_en` is low and `hpll_free` is high exactly while `no_signal` is high.
- R8: Synchronous active-high `rst` gives `no_signal`=1, `vref`=0, `frame_pol`=0 and a counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-clock strobe per video line |
| vsync_det | input | 1 | One-clock strobe per separated vertical sync |
| std_pal | input | 1 | Standard select: 0 = 525-line, 1 = 625-line |
| no_signal | output | 1 | Input considered lost |
| vref | output | 1 | Vertical reference for the vertical drive and start generators |
| frame_pol | output | 1 | Frame-reversal polarity, toggles once per field |
| pd_drive_en | output | 1 | Phase-detector output enable; low means tri-stated |
| hpll_free | output | 1 | Horizontal PLL counter runs free |

## Verification
The bench targets the exact wrap line in both standards. A design that is off by one would declare loss a line early or a line late. It flips the standard in the middle of a period, where a design that does not latch the standard would cut the period short. It drives a vertical sync in the same cycle as a line strobe; a design with the priority reversed would miss the counter restart. It also ends a free-running reference pulse with a sync, where a design that does not clear the pulse would hold `vref` for extra clocks or skip a polarity toggle.

// File: rtl/sld_pkg.sv
package sld_pkg;
    localparam int NTSC_LINES = 269;
    localparam int PAL_LINES  = 321;
    localparam int CNT_W      = $clog2(PAL_LINES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pal;
    } lc_state_t;

    typedef struct packed {
        logic ns;
        logic line_ref;
        logic sync_ref;
        logic pol;
    } ctl_state_t;
endpackage

// File: rtl/sld_line_counter.sv
module sld_line_counter
    import sld_pkg::*;
#(
    parameter int NTSC_N = NTSC_LINES,
    parameter int PAL_N  = PAL_LINES,
    localparam int W     = $clog2(PAL_N > NTSC_N ? PAL_N : NTSC_N)
) (
    input  logic clk,
    input  logic rst,
    input  logic line_tick,
    input  logic restart,
    input  logic std_pal,
    output logic wrap
);
    localparam logic [W-1:0] NTSC_TC = W'(NTSC_N - 1);
    localparam logic [W-1:0] PAL_TC  = W'(PAL_N - 1);

    logic [W-1:0] cnt_q, cnt_d, tc;
    logic         pal_q, pal_d;

    always_comb begin
        tc    = pal_q ? PAL_TC : NTSC_TC;
        wrap  = line_tick && !restart && (cnt_q == tc);
        cnt_d = cnt_q;
        pal_d = pal_q;
        if (restart) begin
            cnt_d = '0;
        end else if (wrap) begin
            cnt_d = '0;
            pal_d = std_pal;
        end else if (line_tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pal_q <= std_pal;
        end else begin
            cnt_q <= cnt_d;
            pal_q <= pal_d;
        end
    end

    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= tc);
    a_r3_std_held: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wrap)) |-> $stable(pal_q));
    a_r2_restart_zero: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0));
endmodule

// File: rtl/sld_loss_ctrl.sv
module sld_loss_ctrl
    import sld_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_tick,
    input  logic restart,
    input  logic wrap,
    output logic no_signal,
    output logic vref,
    output logic frame_pol
);
    ctl_state_t s_q, s_d;

    always_comb begin
        s_d          = s_q;
        s_d.sync_ref = restart;
        if (restart) begin
            s_d.ns       = 1'b0;
            s_d.line_ref = 1'b0;
            s_d.pol      = ~s_q.pol;
        end else if (wrap) begin
            s_d.ns       = 1'b1;
            s_d.line_ref = 1'b1;
            s_d.pol      = ~s_q.pol;
        end else if (line_tick) begin
            s_d.line_ref = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{ns: 1'b1, line_ref: 1'b0, sync_ref: 1'b0, pol: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign no_signal = s_q.ns;
    assign vref      = s_q.sync_ref | s_q.line_ref;
    assign frame_pol = s_q.pol;

    a_r2_sync_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!no_signal && vref));
    a_r4_line_ref_in_loss: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.line_ref) |-> no_signal);
    a_r6_pol_with_vref: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(frame_pol)) |-> vref);
    a_r1_wrap_sets_loss: assert property (@(posedge clk) disable iff (rst)
        wrap |=> no_signal);
endmodule

// File: rtl/sync_loss_detect.sv
module sync_loss_detect
    import sld_pkg::*;
#(
    parameter int NTSC_N = NTSC_LINES,
    parameter int PAL_N  = PAL_LINES
) (
    input  logic clk,
    input  logic rst,
    input  logic line_tick,
    input  logic vsync_det,
    input  logic std_pal,
    output logic no_signal,
    output logic vref,
    output logic frame_pol,
    output logic pd_drive_en,
    output logic hpll_free
);
    logic wrap;

    sld_line_counter #(.NTSC_N(NTSC_N), .PAL_N(PAL_N)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .line_tick (line_tick),
        .restart   (vsync_det),
        .std_pal   (std_pal),
        .wrap      (wrap)
    );

    sld_loss_ctrl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .line_tick (line_tick),
        .restart   (vsync_det),
        .wrap      (wrap),
        .no_signal (no_signal),
        .vref      (vref),
        .frame_pol (frame_pol)
    );

    assign pd_drive_en = ~no_signal;
    assign hpll_free   = no_signal;

    a_r7_float_in_loss: assert property (@(posedge clk) disable iff (rst)
        no_signal |-> (!pd_drive_en && hpll_free));
endmodule

// File: tb/sync_loss_detect_bench.sv
module sync_loss_detect_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_tick = 1'b0, vsync_det = 1'b0, std_pal = 1'b0;
    logic no_signal, vref, frame_pol, pd_drive_en, hpll_free;
    int   n_run = 0, n_fail = 0;

    int   m_cnt;
    logic m_pal, m_ns, m_lr, m_sr, m_pol;

    always #4 clk = ~clk;

    sync_loss_detect u_sync_loss_detect (
        .clk(clk), .rst(rst), .line_tick(line_tick), .vsync_det(vsync_det),
        .std_pal(std_pal), .no_signal(no_signal), .vref(vref),
        .frame_pol(frame_pol), .pd_drive_en(pd_drive_en), .hpll_free(hpll_free)
    );

    function automatic int period(input logic pal);
        return pal ? 321 : 269;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_update();
        if (rst) begin
            m_cnt = 0; m_pal = std_pal; m_ns = 1; m_lr = 0; m_sr = 0; m_pol = 0;
        end else begin
            m_sr = vsync_det;
            if (vsync_det) begin
                m_cnt = 0; m_ns = 0; m_lr = 0; m_pol = ~m_pol;
            end else if (line_tick) begin
                if (m_cnt == period(m_pal) - 1) begin
                    m_cnt = 0; m_pal = std_pal; m_ns = 1; m_lr = 1; m_pol = ~m_pol;
                end else begin
                    m_cnt++; m_lr = 0;
                end
            end
        end
    endtask

    task automatic compare();
        check(no_signal == m_ns, "R1 no_signal", no_signal, m_ns);
        check(vref == (m_sr | m_lr), m_ns ? "R4 vref" : "R5 vref", vref, m_sr | m_lr);
        check(frame_pol == m_pol, "R6 frame_pol", frame_pol, m_pol);
        check(pd_drive_en == !m_ns && hpll_free == m_ns, "R7 enables",
              {pd_drive_en, hpll_free}, {!m_ns, m_ns});
    endtask

    task automatic step(input logic vs, input logic lt);
        vsync_det = vs; line_tick = lt;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic line(input logic vs);
        step(vs, 1'b1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        #1_400_000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        @(negedge clk);
        step(0, 0); step(0, 0);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check(no_signal == 1 && vref == 0 && frame_pol == 0, "R8 reset",
              {no_signal, vref, frame_pol}, 3'b100);
        // R2 sync clears loss; R5 one-clock pulse
        step(1, 0);
        check(no_signal == 0 && vref == 1, "R2 clear", {no_signal, vref}, 2'b01);
        step(0, 0);
        check(vref == 0, "R5 pulse width", vref, 0);
        // R1 525-line period, with R3 std flipped mid-period
        for (int i = 0; i < 268; i++) begin
            line(0);
            if (i == 100) std_pal = 1'b1;
        end
        check(no_signal == 0, "R1 before wrap 269", no_signal, 0);
        line(0);
        check(no_signal == 1, "R3 ntsc held / R1 wrap 269", no_signal, 1);
        // R4 one-line pulse: high through the line, cleared by the next tick
        check(vref == 1, "R4 line pulse high", vref, 1);
        step(0, 1);
        check(vref == 0, "R4 line pulse end", vref, 0);
        step(0, 0); step(0, 0); step(0, 0);
        // now 625-line period latched; 1 tick already counted
        for (int i = 0; i < 319; i++) line(0);
        check(no_signal == 1 && vref == 0, "R3 pal not yet wrapped", vref, 0);
        line(0);
        check(vref == 1, "R1 wrap 321", vref, 1);
        // R2 sync together with a tick: restart wins, pulse ended by sync
        step(1, 1);
        check(no_signal == 0 && vref == 1, "R2 priority", {no_signal, vref}, 2'b01);
        std_pal = 1'b0;
        // random phase
        for (int f = 0; f < 60; f++) begin
            int lines = 200 + int'($urandom_range(0, 180));
            for (int l = 0; l < lines; l++) begin
                if ($urandom_range(0, 40) == 0) std_pal = ~std_pal;
                if ($urandom_range(0, 3) == 0) step($urandom_range(0, 150) == 0, 1'b1);
                else line($urandom_range(0, 300) == 0);
            end
            if ($urandom_range(0, 2) != 0) step(1, $urandom_range(0, 1));
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule